// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block turns one burst command into the ordered list of column addresses that a DDR2-style memory touches during that burst. A small settings port holds the burst length (four or eight beats) and the burst order (sequential or interleaved). A command port takes a starting column and a read/write flag. After it accepts a command, the block emits one column per clock with a valid strobe. It flags the final beat and carries the read/write flag alongside every beat.

Each burst stays inside an aligned block of columns the size of the burst length. The column bits above that block size identify the block and do not change for the whole burst. The low bits of the starting column only pick the entry point. Sequential order counts upward from that point and wraps within the block. Interleaved order XORs the entry point with the beat index. Settings are captured when a command is accepted, so a burst always runs with one consistent length and order.

Top module: `burst_colseq`

## Requirements
- R1: A settings write with `mode_data[2:0]` = 3'b010 selects a 4-beat burst and 3'b011 selects an 8-beat burst. `mode_data[3]` = 1 selects interleaved order and 0 selects sequential order. After reset the settings are 4 beats, sequential.
- R2: A settings write from idle with any other length code (000, 001, 1xx) raises `mode_err` for exactly the one cycle that follows the write and leaves both settings unchanged. A valid write never raises `mode_err`.
- R3: In sequential order, the low offset of beat i (2 bits for 4 beats, 3 bits for 8 beats) equals (start offset + i) modulo the burst length.
- R4: In interleaved order, the low offset of beat i equals the start offset XOR i.
- R5: For every beat, the column bits above the offset (bit 2 and up for 4 beats, bit 3 and up for 8 beats) equal those of the starting column.
- R6: Beat 0 appears in the cycle after the command is accepted. Beats then follow one per clock with `beat_valid` high and no gaps. `beat_last` is high only on beat BL-1.
- R7: `busy` is high from the cycle after acceptance through the last beat. A command presented while `busy` is high is ignored.
- R8: `beat_write` equals the command's write flag on every beat, and reads and writes use the same length and order settings.
- R9: A settings write while `busy` is high has no effect and raises no `mode_err`.
- R10: A burst uses the settings in force at its acceptance edge. A settings write in that same cycle applies only to later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Settings write strobe |
| mode_data | input | 4 | [2:0] length code, [3] order select |
| mode_err | output | 1 | One-cycle pulse after a rejected length code |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_col | input | COL_W | Starting column of the burst |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| busy | output | 1 | Burst in progress |
| beat_valid | output | 1 | A column address is presented this cycle |
| beat_col | output | COL_W | Column address of the current beat |
| beat_write | output | 1 | Write flag of the current burst |
| beat_last | output | 1 | Final beat of the burst |

## Verification
The assertions assume that reset is held for at least one clock edge and that `cmd_col` is a known value whenever `cmd_valid` is high. They also assume that `mode_wr` and `cmd_valid` stay low during reset. The stimulus drives all inputs on the falling edge and holds them low during reset. It presents commands both when idle and deliberately while busy. It issues settings writes with every length code, including writes during a burst and in the same cycle as a command, so the rejection and latching rules are exercised without leaving those assumptions.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int OFF_W = 3;
    localparam logic [2:0] LEN4_CODE = 3'b010;
    localparam logic [2:0] LEN8_CODE = 3'b011;

    typedef struct packed {
        logic len8;
        logic ilv;
    } burst_cfg_t;
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_data,
    input  logic       hold,
    output burst_cfg_t cfg,
    output logic       err
);
    typedef struct packed {
        burst_cfg_t cfg;
        logic       err;
    } mode_state_t;

    mode_state_t st_d, st_q;
    logic        take;
    logic        code_ok;

    always_comb begin
        st_d    = st_q;
        st_d.err = 1'b0;
        take    = wr_en && !hold;
        code_ok = (wr_data[2:0] == LEN4_CODE) || (wr_data[2:0] == LEN8_CODE);
        if (take) begin
            if (code_ok) begin
                st_d.cfg.len8 = (wr_data[2:0] == LEN8_CODE);
                st_d.cfg.ilv  = wr_data[3];
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;
    assign err = st_q.err;

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(cfg.len8) && $stable(cfg.ilv) && !err));

    assert_err_after_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(wr_en));

    assert_err_keeps_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(cfg.len8) && $stable(cfg.ilv)));
endmodule

// File: rtl/burst_order_calc.sv
module burst_order_calc
    import burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [OFF_W-1:0] beat_idx,
    input  logic             len8,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [OFF_W-1:0] mask;
    logic [OFF_W-1:0] seq_off;
    logic [OFF_W-1:0] ilv_off;
    logic [OFF_W-1:0] off;

    always_comb begin
        mask    = len8 ? 3'b111 : 3'b011;
        seq_off = start_col[OFF_W-1:0] + beat_idx;
        ilv_off = start_col[OFF_W-1:0] ^ beat_idx;
        off     = ilv ? ilv_off : seq_off;
    end

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        if (b < OFF_W) begin : g_low
            assign col[b] = mask[b] ? off[b] : start_col[b];
        end else begin : g_high
            assign col[b] = start_col[b];
        end
    end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
    import burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_write,
    input  burst_cfg_t       cfg,
    output logic             active,
    output logic [OFF_W-1:0] idx,
    output logic [COL_W-1:0] start_col,
    output burst_cfg_t       run_cfg,
    output logic             run_write,
    output logic             last
);
    typedef struct packed {
        logic             active;
        logic [OFF_W-1:0] idx;
        logic [COL_W-1:0] start;
        burst_cfg_t       cfg;
        logic             write;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic [OFF_W-1:0] last_idx;

    always_comb begin
        last_idx = st_q.cfg.len8 ? 3'd7 : 3'd3;
        st_d     = st_q;
        if (!st_q.active) begin
            if (cmd_valid) begin
                st_d.active = 1'b1;
                st_d.idx    = '0;
                st_d.start  = cmd_col;
                st_d.cfg    = cfg;
                st_d.write  = cmd_write;
            end
        end else if (st_q.idx == last_idx) begin
            st_d.active = 1'b0;
            st_d.idx    = '0;
        end else begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active    = st_q.active;
    assign idx       = st_q.idx;
    assign start_col = st_q.start;
    assign run_cfg   = st_q.cfg;
    assign run_write = st_q.write;
    assign last      = st_q.active && (st_q.idx == last_idx);

    assert_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> active);

    assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !active);

    assert_start_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> $stable(start_col));

    assert_flag_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> ($stable(run_write) && $stable(run_cfg.len8) && $stable(run_cfg.ilv)));
endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
    import burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [3:0]       mode_data,
    output logic             mode_err,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_write,
    output logic             busy,
    output logic             beat_valid,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_write,
    output logic             beat_last
);
    burst_cfg_t       cur_cfg;
    burst_cfg_t       run_cfg;
    logic             active;
    logic [OFF_W-1:0] idx;
    logic [COL_W-1:0] start_col;
    logic             run_write;
    logic             last;

    burst_mode_reg mode_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wr_data (mode_data),
        .hold    (active),
        .cfg     (cur_cfg),
        .err     (mode_err)
    );

    burst_beat_ctrl #(.COL_W(COL_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_col   (cmd_col),
        .cmd_write (cmd_write),
        .cfg       (cur_cfg),
        .active    (active),
        .idx       (idx),
        .start_col (start_col),
        .run_cfg   (run_cfg),
        .run_write (run_write),
        .last      (last)
    );

    burst_order_calc #(.COL_W(COL_W)) order_i (
        .start_col (start_col),
        .beat_idx  (idx),
        .len8      (run_cfg.len8),
        .ilv       (run_cfg.ilv),
        .col       (beat_col)
    );

    assign busy       = active;
    assign beat_valid = active;
    assign beat_write = run_write;
    assign beat_last  = last;

    assert_block_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> (beat_col[COL_W-1:OFF_W] == $past(beat_col[COL_W-1:OFF_W])));

    assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);
endmodule

// File: tb/burst_colseq_tb_top.sv
`timescale 1ns/1ps
module burst_colseq_tb_top;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_wr = 1'b0;
    logic [3:0]       mode_data = '0;
    logic             mode_err;
    logic             cmd_valid = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cmd_write = 1'b0;
    logic             busy, beat_valid, beat_write, beat_last;
    logic [COL_W-1:0] beat_col;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    burst_colseq #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_data(mode_data),
        .mode_err(mode_err), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
        .cmd_write(cmd_write), .busy(busy), .beat_valid(beat_valid),
        .beat_col(beat_col), .beat_write(beat_write), .beat_last(beat_last)
    );

    // Behavioural reference model
    int m_len = 4, m_ilv = 0, m_err = 0;
    int m_act = 0, m_i = 0, m_start = 0, m_wr = 0, m_rlen = 4, m_rilv = 0;

    always @(posedge clk) begin
        int nl, ni, ne, code;
        if (!rst_n) begin
            m_len = 4; m_ilv = 0; m_err = 0; m_act = 0; m_i = 0;
            m_start = 0; m_wr = 0; m_rlen = 4; m_rilv = 0;
        end else begin
            nl = m_len; ni = m_ilv; ne = 0;
            code = int'(mode_data[2:0]);
            if (mode_wr && m_act == 0) begin
                if (code == 2)      begin nl = 4; ni = int'(mode_data[3]); end
                else if (code == 3) begin nl = 8; ni = int'(mode_data[3]); end
                else ne = 1;
            end
            if (m_act == 0) begin
                if (cmd_valid) begin
                    m_act = 1; m_i = 0; m_start = int'(cmd_col);
                    m_wr = int'(cmd_write); m_rlen = m_len; m_rilv = m_ilv;
                end
            end else if (m_i == m_rlen - 1) begin
                m_act = 0; m_i = 0;
            end else begin
                m_i = m_i + 1;
            end
            m_len = nl; m_ilv = ni; m_err = ne;
        end
    end

    function automatic int exp_col();
        int s, low;
        s = m_start % m_rlen;
        low = m_rilv ? (s ^ m_i) : ((s + m_i) % m_rlen);
        return m_start - s + low;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 R9 mode_err", int'(mode_err), m_err);
            chk("R7 busy", int'(busy), m_act);
            chk("R6 beat_valid", int'(beat_valid), m_act);
            if (m_act != 0) begin
                chk("R3 R4 R5 R10 beat_col", int'(beat_col), exp_col());
                chk("R6 beat_last", int'(beat_last), (m_i == m_rlen - 1) ? 1 : 0);
                chk("R8 beat_write", int'(beat_write), m_wr);
            end
        end
    end

    task automatic mode_write(input logic [3:0] d);
        @(negedge clk); mode_wr = 1'b1; mode_data = d;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic issue(input int col, input bit wr);
        @(negedge clk); cmd_valid = 1'b1; cmd_col = COL_W'(col); cmd_write = wr;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic burst(input int col, input bit wr);
        issue(col, wr);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, idle and no error
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset mode_err", int'(mode_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R3 R5: default 4-beat sequential, every start offset
        for (int s = 0; s < 8; s++) burst(16'h1A8 + s, s[0]);
        // R1 R3: 8-beat sequential
        mode_write(4'b0011);
        for (int s = 0; s < 8; s++) burst(16'h2F0 + s, 1'b0);
        // R4: 8-beat interleaved
        mode_write(4'b1011);
        for (int s = 0; s < 8; s++) burst(16'h0C8 + s, 1'b1);
        // R4: 4-beat interleaved
        mode_write(4'b1010);
        for (int s = 0; s < 8; s++) burst(16'h3F8 + s, 1'b0);
        // R2: reserved codes rejected, settings retained
        mode_write(4'b0000); mode_write(4'b1001); mode_write(4'b0100); mode_write(4'b0111);
        burst(16'h155, 1'b1);
        // R9: settings write during a burst ignored
        mode_write(4'b0011);
        issue(16'h013, 1'b0);
        @(negedge clk); mode_wr = 1'b1; mode_data = 4'b1010;
        @(negedge clk); mode_wr = 1'b0;
        wait_idle();
        burst(16'h016, 1'b1);
        // R7: command while busy ignored
        issue(16'h200, 1'b0);
        @(negedge clk); cmd_valid = 1'b1; cmd_col = 10'h3FF; cmd_write = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        wait_idle();
        // R10: settings write in the acceptance cycle applies afterwards
        @(negedge clk);
        mode_wr = 1'b1; mode_data = 4'b1010; cmd_valid = 1'b1; cmd_col = 10'h0A5; cmd_write = 1'b0;
        @(negedge clk); mode_wr = 1'b0; cmd_valid = 1'b0;
        wait_idle();
        burst(16'h0A5, 1'b1);
        // Mixed random traffic
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            mode_wr   = ($urandom_range(0, 3) == 0);
            mode_data = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1) mode_data[2:1] = 2'b01;
            cmd_valid = ($urandom_range(0, 2) != 0);
            cmd_col   = COL_W'($urandom);
            cmd_write = 1'($urandom_range(0, 1));
        end
        @(negedge clk); mode_wr = 1'b0; cmd_valid = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule